// File: doc/BRIEF.md
# Failing Row Column Sweep Sequencer

After an ECC error in a DRAM row, every system page that maps into that row has to be taken out of service. This sequencer takes the 28-bit device address of the error and replaces its five-bit column field with each value from 0 to 31, in order. It sends each of these addresses to an external translator and waits for the answer before it moves to the next column.

A successful answer is a system address. The sequencer derives a page number from that address and checks it against an external page-status lookup. A retire request goes out for the page only when the page is online and not already poisoned. When a translation fails, or the page is offline or poisoned, the sequencer skips that column and the sweep carries on.

A done pulse marks the end of the sweep, and the number of retire requests issued during the sweep is then available. The sweep runs only on the heterogeneous fabric configuration. On any other configuration a start produces only the done pulse.

Top module: `row_sweep_seq`

## Requirements
- R1: An accepted sweep issues exactly 32 translation requests (one-cycle pulses on `xl_req_o`), with column values 0, 1, …, 31 in increasing order.
- R2: Each request address equals the latched error address with bits 5:1 replaced by the column value. All other bits are unchanged, whatever the incoming column bits were.
- R3: Only one translation is in flight at a time. No new request is issued before the response (`xl_vld_i`) to the previous one.
- R4: A response with `xl_err_i`=1 produces no retire request for that column, and the sweep continues with the next column.
- R5: A page reported with `pg_online_i`=0 is not retired.
- R6: A page reported with `pg_poison_i`=1 is not retired.
- R7: The page number on `pg_query_o` and `rt_page_o` is the translated system address shifted right by 12 bits. `rt_req_o` and `rt_page_o` stay stable until the cycle in which `rt_ack_i` is seen.
- R8: When done is signalled, `rt_count_o` equals the number of acknowledged retire requests of that sweep. It is cleared by every accepted start.
- R9: `done_o` is a single-cycle pulse that follows the last column of a sweep.
- R10: A start with `hetero_i`=0 issues no translation request and produces `done_o` in the cycle after the start cycle, with `rt_count_o`=0.
- R11: A start that arrives while a sweep is running is ignored. The sweep keeps its original address, and no second sweep follows.
- R12: After reset, `xl_req_o`, `rt_req_o` and `done_o` are low and `rt_count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a sweep |
| hetero_i | input | 1 | Configuration flag: heterogeneous fabric variant |
| err_addr_i | input | 28 | Device address of the failing location |
| xl_req_o | output | 1 | Translation request pulse |
| xl_addr_o | output | 28 | Address to translate |
| xl_vld_i | input | 1 | Translation response valid |
| xl_err_i | input | 1 | Translation failed |
| xl_sys_i | input | 40 | Translated system address |
| pg_query_o | output | 28 | Page number sent to the status lookup |
| pg_online_i | input | 1 | Queried page is online |
| pg_poison_i | input | 1 | Queried page is already poisoned |
| rt_req_o | output | 1 | Retire request, held until acknowledged |
| rt_page_o | output | 28 | Page number to retire |
| rt_ack_i | input | 1 | Retire acknowledge |
| done_o | output | 1 | Sweep finished pulse |
| rt_count_o | output | 6 | Retire requests issued in the last sweep |

## Verification
The sweep is run on a clean row, where every column retires. This separates the column stepping and field replacement from the filtering. Separate runs then place translation errors, offline pages and poisoned pages on scattered columns, including column 0, column 31 and columns that overlap between categories. Each case must remove exactly its own pages from the retire stream and from the count. The incoming error addresses have their column bits set, so a sweep that merges the column value with the old bits instead of replacing them shows up. One run with every translation failing, a run on the non-heterogeneous configuration and a start pulse injected mid-sweep cover the paths that never retire and the paths that must not restart.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_REQ,
      S_WAIT,
      S_CHECK,
      S_RETIRE,
      S_NEXT,
      S_DONE
   } sweep_state_e;
endpackage

// File: rtl/sweep_col_ctr.sv
module sweep_col_ctr #(
   parameter int COL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [COL_W-1:0] col_o,
   output logic             last_o
);
   localparam logic [COL_W-1:0] LAST = {COL_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) col_o <= '0;
      else if (inc_i && !last_o) col_o <= col_o + 1'b1;
   end

   assign last_o = (col_o == LAST);

   a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i && last_o) |=> (col_o == LAST));
endmodule

// File: rtl/sweep_addr_patch.sv
module sweep_addr_patch #(
   parameter int ADDR_W = 28,
   parameter int COL_LO = 1,
   parameter int COL_W  = 5
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [COL_W-1:0]  col_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int COL_HI = COL_LO + COL_W - 1;

   if (COL_HI >= ADDR_W) begin : g_bad_field
      $error("column field exceeds address width");
   end

   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      if (b >= COL_LO && b <= COL_HI) begin : g_col
         assign addr_o[b] = col_i[b-COL_LO];
      end else begin : g_keep
         assign addr_o[b] = base_i[b];
      end
   end
endmodule

// File: rtl/sweep_page_gate.sv
module sweep_page_gate #(
   parameter int SYS_W      = 40,
   parameter int PAGE_SHIFT = 12,
   localparam int PAGE_W    = SYS_W - PAGE_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_i,
   input  logic [SYS_W-1:0]  sys_i,
   input  logic              online_i,
   input  logic              poison_i,
   output logic [PAGE_W-1:0] page_o,
   output logic              usable_o
);
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= SYS_W) begin : g_bad_shift
      $error("page shift out of range");
   end

   logic [PAGE_W-1:0] page_q;

   always_ff @(posedge clk) begin
      if (!rst_n) page_q <= '0;
      else if (cap_i) page_q <= sys_i[SYS_W-1:PAGE_SHIFT];
   end

   assign page_o   = page_q;
   assign usable_o = online_i && !poison_i;

   a_r7_page_shift: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (page_o == $past(sys_i[SYS_W-1:PAGE_SHIFT])));
endmodule

// File: rtl/row_sweep_seq.sv
module row_sweep_seq
   import sweep_pkg::*;
#(
   parameter int ADDR_W     = 28,
   parameter int COL_LO     = 1,
   parameter int COL_W      = 5,
   parameter int SYS_W      = 40,
   parameter int PAGE_SHIFT = 12,
   localparam int PAGE_W    = SYS_W - PAGE_SHIFT,
   localparam int CNT_W     = COL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              hetero_i,
   input  logic [ADDR_W-1:0] err_addr_i,
   output logic              xl_req_o,
   output logic [ADDR_W-1:0] xl_addr_o,
   input  logic              xl_vld_i,
   input  logic              xl_err_i,
   input  logic [SYS_W-1:0]  xl_sys_i,
   output logic [PAGE_W-1:0] pg_query_o,
   input  logic              pg_online_i,
   input  logic              pg_poison_i,
   output logic              rt_req_o,
   output logic [PAGE_W-1:0] rt_page_o,
   input  logic              rt_ack_i,
   output logic              done_o,
   output logic [CNT_W-1:0]  rt_count_o
);
   sweep_state_e      st_q, st_d;
   logic [ADDR_W-1:0] base_q;
   logic [COL_W-1:0]  col;
   logic              col_last, col_clr, col_inc;
   logic              cap, usable;
   logic [PAGE_W-1:0] page;
   logic              go_sweep, go_skip;

   assign go_sweep = (st_q == S_IDLE) && start_i && hetero_i;
   assign go_skip  = (st_q == S_IDLE) && start_i && !hetero_i;
   assign cap      = (st_q == S_WAIT) && xl_vld_i;
   assign col_clr  = go_sweep;
   assign col_inc  = (st_q == S_NEXT) && !col_last;

   sweep_col_ctr #(.COL_W(COL_W)) u_col (
      .clk(clk), .rst_n(rst_n), .clr_i(col_clr), .inc_i(col_inc),
      .col_o(col), .last_o(col_last)
   );

   sweep_addr_patch #(.ADDR_W(ADDR_W), .COL_LO(COL_LO), .COL_W(COL_W)) u_patch (
      .base_i(base_q), .col_i(col), .addr_o(xl_addr_o)
   );

   sweep_page_gate #(.SYS_W(SYS_W), .PAGE_SHIFT(PAGE_SHIFT)) u_gate (
      .clk(clk), .rst_n(rst_n), .cap_i(cap), .sys_i(xl_sys_i),
      .online_i(pg_online_i), .poison_i(pg_poison_i),
      .page_o(page), .usable_o(usable)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE:   if (go_sweep) st_d = S_REQ;
                   else if (go_skip) st_d = S_DONE;
         S_REQ:    st_d = S_WAIT;
         S_WAIT:   if (xl_vld_i) st_d = xl_err_i ? S_NEXT : S_CHECK;
         S_CHECK:  st_d = usable ? S_RETIRE : S_NEXT;
         S_RETIRE: if (rt_ack_i) st_d = S_NEXT;
         S_NEXT:   st_d = col_last ? S_DONE : S_REQ;
         S_DONE:   st_d = S_IDLE;
         default:  st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         base_q     <= '0;
         rt_count_o <= '0;
      end else begin
         st_q <= st_d;
         if (go_sweep) base_q <= err_addr_i;
         if (go_sweep || go_skip) rt_count_o <= '0;
         else if (st_q == S_RETIRE && rt_ack_i) rt_count_o <= rt_count_o + 1'b1;
      end
   end

   assign xl_req_o   = (st_q == S_REQ);
   assign rt_req_o   = (st_q == S_RETIRE);
   assign rt_page_o  = page;
   assign pg_query_o = page;
   assign done_o     = (st_q == S_DONE);

   logic infl_q;
   always_ff @(posedge clk) begin
      if (!rst_n) infl_q <= 1'b0;
      else if (xl_req_o) infl_q <= 1'b1;
      else if (xl_vld_i) infl_q <= 1'b0;
   end

   a_r3_one_inflight: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req_o |-> !infl_q);
   a_r4_err_skips: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WAIT && xl_vld_i && xl_err_i) |=> !rt_req_o && !xl_req_o);
   a_r5_r6_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_CHECK && (!pg_online_i || pg_poison_i)) |=> !rt_req_o);
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_req_o && !rt_ack_i) |=> rt_req_o && $stable(rt_page_o));
   a_r8_count: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_req_o && rt_ack_i) |=> rt_count_o == $past(rt_count_o) + 1'b1);
   a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r10_skip: assert property (@(posedge clk) disable iff (!rst_n)
      go_skip |=> done_o && !xl_req_o);
   a_r11_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != S_IDLE) |=> $stable(base_q));
endmodule

// File: tb/row_sweep_seq_test.sv
module row_sweep_seq_test;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [27:0] KEY = 28'h0A5_0000;

   logic clk = 0, rst_n = 0;
   logic start_i = 0, hetero_i = 0;
   logic [27:0] err_addr_i = '0;
   logic xl_req_o, xl_vld_i = 0, xl_err_i = 0;
   logic [27:0] xl_addr_o;
   logic [39:0] xl_sys_i = '0;
   logic [27:0] pg_query_o, rt_page_o;
   logic pg_online_i, pg_poison_i;
   logic rt_req_o, rt_ack_i = 0, done_o;
   logic [5:0] rt_count_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   row_sweep_seq uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .hetero_i(hetero_i),
      .err_addr_i(err_addr_i), .xl_req_o(xl_req_o), .xl_addr_o(xl_addr_o),
      .xl_vld_i(xl_vld_i), .xl_err_i(xl_err_i), .xl_sys_i(xl_sys_i),
      .pg_query_o(pg_query_o), .pg_online_i(pg_online_i), .pg_poison_i(pg_poison_i),
      .rt_req_o(rt_req_o), .rt_page_o(rt_page_o), .rt_ack_i(rt_ack_i),
      .done_o(done_o), .rt_count_o(rt_count_o)
   );

   int nchk = 0, nerr = 0;
   logic [31:0] err_m = 0, off_m = 0, poi_m = 0;
   logic [27:0] base = 0;
   int nreq = 0, exp_nreq = 0, exp_cnt = 0, ndone = 0, cycles = 0;
   logic [27:0] expq[$];
   bit infl = 0, prev_done = 0;
   int lat = 0, rwait = 0, nret = 0;
   logic [27:0] req_addr = 0, held_page = 0;
   bit holding = 0;

   task automatic chk(bit ok, string tag, longint act, longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [27:0] patch(logic [27:0] b, int c);
      logic [27:0] r = b;
      r[5:1] = 5'(c);
      return r;
   endfunction

   always_comb begin
      logic [27:0] a;
      a = pg_query_o ^ KEY;
      pg_online_i = !off_m[a[5:1]];
      pg_poison_i = poi_m[a[5:1]];
   end

   // reference model: translator, retire target and sweep scoreboard
   always @(negedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         nerr++; nchk++;
         $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
      xl_vld_i = 0;
      if (rt_ack_i) begin rt_ack_i = 0; holding = 0; end
      else if (rst_n) begin
         if (xl_req_o) begin
            chk(!infl, "R3 request while in flight", 1, 0);
            chk(xl_addr_o == patch(base, nreq), "R1 R2 request address",
                xl_addr_o, patch(base, nreq));
            nreq++;
            infl = 1; req_addr = xl_addr_o; lat = 1 + (int'(xl_addr_o[5:1]) % 3);
         end else if (infl) begin
            lat--;
            if (lat == 0) begin
               xl_vld_i = 1;
               xl_err_i = err_m[req_addr[5:1]];
               xl_sys_i = {req_addr ^ KEY, 12'h3C5};
               infl = 0;
            end
         end
         if (rt_req_o) begin
            if (!holding) begin
               holding = 1; held_page = rt_page_o; rwait = nret % 3;
            end else
               chk(rt_page_o == held_page, "R7 page held", rt_page_o, held_page);
            if (rwait == 0) begin
               chk(expq.size() > 0 && rt_page_o == expq[0], "R4 R5 R6 R7 retire page",
                   rt_page_o, expq.size() > 0 ? expq[0] : 28'hx);
               if (expq.size() > 0) void'(expq.pop_front());
               rt_ack_i = 1; nret++;
            end else rwait--;
         end
         if (done_o) begin
            chk(!prev_done, "R9 single pulse", 1, 0);
            chk(nreq == exp_nreq, "R1 R9 request count at done", nreq, exp_nreq);
            chk(expq.size() == 0, "R4 R5 R6 missing retires", expq.size(), 0);
            chk(rt_count_o == 6'(exp_cnt), "R8 retire count", rt_count_o, exp_cnt);
            ndone++;
         end
      end
      prev_done = done_o;
   end

   task automatic run(logic [27:0] b, bit het, logic [31:0] em, logic [31:0] om,
                      logic [31:0] pm, bit mid);
      int d0;
      err_m = em; off_m = om; poi_m = pm; base = b;
      expq.delete(); exp_cnt = 0; nreq = 0;
      exp_nreq = het ? 32 : 0;
      if (het)
         for (int c = 0; c < 32; c++)
            if (!em[c] && !om[c] && !pm[c]) begin
               expq.push_back(patch(b, c) ^ KEY); exp_cnt++;
            end
      d0 = ndone;
      @(negedge clk);
      hetero_i = het; err_addr_i = b; start_i = 1;
      @(negedge clk);
      start_i = 0;
      if (!het) begin
         chk(done_o == 1, "R10 done after start", done_o, 1);
         chk(xl_req_o == 0, "R10 no request", xl_req_o, 0);
      end
      if (mid) begin
         repeat (20) @(negedge clk);
         err_addr_i = ~b; start_i = 1;
         @(negedge clk);
         start_i = 0;
      end
      for (int i = 0; i < 3000 && ndone == d0; i++) @(negedge clk);
      chk(ndone == d0 + 1, "R9 done seen", ndone - d0, 1);
      repeat (6) @(negedge clk);
      chk(nreq == exp_nreq && ndone == d0 + 1, "R11 no restart", nreq, exp_nreq);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!xl_req_o && !rt_req_o && !done_o, "R12 reset outputs low",
          {xl_req_o, rt_req_o, done_o}, 0);
      chk(rt_count_o == 0, "R12 reset count", rt_count_o, 0);
      rst_n = 1;
      run(28'h0FF_F03F, 0, 0, 0, 0, 0);                                 // R10
      run(28'hF5A_C03F, 1, 0, 0, 0, 0);                                 // R1 R2 clean
      run(28'h123_4002, 1, 32'h8000_0421, 0, 0, 0);                     // R4
      run(28'h0123_4567, 1, 32'h0001_0002, 32'h0000_F001, 32'h8300_1008, 1); // R5 R6 R11
      run(28'hFFF_FFFF, 1, 32'hFFFF_FFFF, 0, 0, 0);                     // R4 all fail
      run(28'h00A_0000, 0, 0, 0, 0, 0);                                 // R10 R8 cleared
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule